// File: doc/BRIEF.md
# Injection-Stepped Detector Signature Self-Test Controller

This block is the digital sequencer of a built-in self-test for an analog amplifier and its bias network. When a test is started it drives three injection enables (positive input offset, negative input offset and bias-mirror skew) through four fixed injection steps. In each step it waits a programmable number of settle cycles. It then records one bit from each of four digital detectors: a window comparator on the top bias node, one on the n-side bias, one on the p-side bias, and a two-inverter level detector on the amplifier output.

The sixteen recorded bits form a detector-major signature. This signature is compared against a fixed fault-free word. The block reports pass/fail and a per-detector mismatch mask. It also returns the raw signature, so that failing parts with equal signatures can later be grouped for localisation. Outside a test, every injection enable is held low, which leaves the amplifier untouched in normal operation.

Top module: `amp_sig_bist`

## Requirements
- R1: After reset and whenever `busy_o` is low, `inj_pos_o`, `inj_neg_o` and `inj_skew_o` are all 0.
- R2: A run applies four steps in a fixed order. Step 0 is positive offset only, step 1 is negative offset only, step 2 is skew with positive offset, and step 3 is skew with negative offset.
- R3: `inj_pos_o` and `inj_neg_o` are never 1 in the same cycle.
- R4: Every step lasts `settle_i`+1 cycles. `done_o` rises 4*(`settle_i`+1) cycles after the clock edge that accepted `start_i`.
- R5: Each detector input passes through two flip-flops and is sampled once per step, in the last cycle of that step. Detector activity while idle does not affect the result. For the current step's level to be captured, `settle_i` must be at least 2.
- R6: The signature bit for detector d (0 = amplifier output, 1 = p-bias, 2 = n-bias, 3 = bias-top) in step s sits at `sig_o[4*d + 3 - s]`. Each detector's nibble therefore reads in step order, starting at its MSB.
- R7: `pass_o` is 1 exactly when `sig_o` equals 16'b1111110000111010. `mism_o[d]` is 1 when nibble d of `sig_o` differs from nibble d of that word.
- R8: `done_o` is a one-cycle pulse with `busy_o` low. In the cycle of that pulse, `sig_o`, `pass_o` and `mism_o` hold the new results, and they stay unchanged until the next run completes.
- R9: A `start_i` pulse while `busy_o` is high is ignored, so the running test keeps its timing.
- R10: Synchronous reset (`rst`) in the middle of a run drops all injection enables and `busy_o` in the next cycle, clears the results to 0, and no `done_o` follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start pulse; honoured only while idle |
| settle_i | input | CNT_W | Settle cycles per step, held during a run |
| det_i | input | 4 | Detector bits: [3] bias-top, [2] n-bias, [1] p-bias, [0] amplifier output |
| inj_pos_o | output | 1 | Positive offset injection enable |
| inj_neg_o | output | 1 | Negative offset injection enable |
| inj_skew_o | output | 1 | Bias-mirror skew enable |
| busy_o | output | 1 | High while a run is in progress |
| done_o | output | 1 | One-cycle completion pulse |
| pass_o | output | 1 | Signature equals the fault-free word |
| sig_o | output | 16 | Captured signature |
| mism_o | output | 4 | Per-detector nibble mismatch mask |

## Verification
The detector model is driven by the injection enables. It starts from the fault-free behaviour and XORs in a chosen fault word, so each run's expected signature, mask and verdict are known ahead of time. A clean run checks that the golden word gives a pass. Single-bit faults placed on each detector in turn show that the nibble positions and the step-to-bit order are right, and that the mask names the correct detector. Random fault words with random settle lengths exercise the packing and the step timing together. Directed cases cover the following:
- random detector noise while idle, which must have no effect;
- a start pulse during a run, which must not change the latency;
- a reset in the middle of a run;
- the shortest usable settle value.

// File: rtl/bist_sig_pkg.sv
package bist_sig_pkg;

    localparam int NUM_DET  = 4;
    localparam int NUM_STEP = 4;
    localparam int SIG_W    = NUM_DET * NUM_STEP;
    localparam int STEP_W   = $clog2(NUM_STEP);

    // Fault-free signature: nibble 3 bias-top .. nibble 0 amplifier output
    localparam logic [SIG_W-1:0] GOLDEN_SIG = 16'b1111_1100_0011_1010;

    typedef enum logic {PH_IDLE, PH_RUN} phase_e;

    typedef struct packed {
        logic pos;
        logic neg;
        logic skew;
    } inj_t;

    // Step 0: +off, 1: -off, 2: skew/+off, 3: skew/-off
    function automatic inj_t inj_for_step(input logic [STEP_W-1:0] s);
        inj_t r;
        r.pos  = ~s[0];
        r.neg  =  s[0];
        r.skew =  s[1];
        return r;
    endfunction

    // Detector-major placement, step order from the nibble MSB down
    function automatic int unsigned sig_pos(input int unsigned d, input int unsigned s);
        return d * NUM_STEP + (NUM_STEP - 1 - s);
    endfunction

endpackage

// File: rtl/det_sync.sv
module det_sync #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] meta_q;
    logic [W-1:0] sync_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q <= '0;
            sync_q <= '0;
        end else begin
            meta_q <= d_i;
            sync_q <= meta_q;
        end
    end

    assign q_o = sync_q;
endmodule

// File: rtl/inj_sequencer.sv
module inj_sequencer
    import bist_sig_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic [CNT_W-1:0]  settle_i,
    output logic              busy_o,
    output logic              accept_o,
    output logic              sample_o,
    output logic              last_o,
    output logic [STEP_W-1:0] step_o,
    output inj_t              inj_o
);
    localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(NUM_STEP - 1);

    phase_e            phase_q;
    logic [STEP_W-1:0] step_q;
    logic [CNT_W-1:0]  cnt_q;
    logic              tick;

    assign accept_o = (phase_q == PH_IDLE) && start_i;
    assign tick     = (phase_q == PH_RUN) && (cnt_q >= settle_i);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_IDLE;
            step_q  <= '0;
            cnt_q   <= '0;
        end else if (accept_o) begin
            phase_q <= PH_RUN;
            step_q  <= '0;
            cnt_q   <= '0;
        end else if (phase_q == PH_RUN) begin
            if (tick) begin
                cnt_q <= '0;
                if (step_q == LAST_STEP) begin
                    phase_q <= PH_IDLE;
                    step_q  <= '0;
                end else begin
                    step_q <= step_q + 1'b1;
                end
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    assign busy_o   = (phase_q == PH_RUN);
    assign sample_o = tick;
    assign last_o   = tick && (step_q == LAST_STEP);
    assign step_o   = step_q;
    assign inj_o    = busy_o ? inj_for_step(step_q) : '0;

    AST_RUN_STARTS_AT_ZERO: assert property (@(posedge clk) disable iff (rst)
        $rose(busy_o) |-> step_q == '0); // R2
    AST_STEP_ADVANCE: assert property (@(posedge clk) disable iff (rst)
        (tick && step_q != LAST_STEP) |=> step_q == $past(step_q) + 1'b1); // R2
    AST_START_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (busy_o && start_i && !tick) |=> busy_o && $stable(step_q)); // R9
    AST_ONE_OFFSET: assert property (@(posedge clk) disable iff (rst)
        !(inj_o.pos && inj_o.neg)); // R3
endmodule

// File: rtl/sig_collect.sv
module sig_collect
    import bist_sig_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              clear_i,
    input  logic              sample_i,
    input  logic              last_i,
    input  logic [STEP_W-1:0] step_i,
    input  logic [NUM_DET-1:0] det_i,
    output logic [SIG_W-1:0]  sig_o,
    output logic [NUM_DET-1:0] mism_o,
    output logic              pass_o,
    output logic              done_o
);
    logic [SIG_W-1:0]   work_q;
    logic [SIG_W-1:0]   work_nx;
    logic [NUM_DET-1:0] grp_miss;
    logic [SIG_W-1:0]   sig_q;
    logic [NUM_DET-1:0] mism_q;
    logic               pass_q;
    logic               done_q;

    always_comb begin
        work_nx = work_q;
        for (int d = 0; d < NUM_DET; d++) begin
            work_nx[sig_pos(d, int'(step_i))] = det_i[d];
        end
    end

    for (genvar g = 0; g < NUM_DET; g++) begin : g_grp
        assign grp_miss[g] =
            work_nx[g*NUM_STEP +: NUM_STEP] != GOLDEN_SIG[g*NUM_STEP +: NUM_STEP];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            work_q <= '0;
            sig_q  <= '0;
            mism_q <= '0;
            pass_q <= 1'b0;
            done_q <= 1'b0;
        end else begin
            done_q <= last_i;
            if (clear_i) begin
                work_q <= '0;
            end else if (sample_i) begin
                work_q <= work_nx;
            end
            if (last_i) begin
                sig_q  <= work_nx;
                mism_q <= grp_miss;
                pass_q <= (grp_miss == '0);
            end
        end
    end

    assign sig_o  = sig_q;
    assign mism_o = mism_q;
    assign pass_o = pass_q;
    assign done_o = done_q;

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done_q |=> !done_q); // R8
    AST_PASS_GOLDEN: assert property (@(posedge clk) disable iff (rst)
        done_q |-> (pass_q == (sig_q == GOLDEN_SIG))); // R7
    AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (rst)
        !last_i |=> $stable(sig_q) && $stable(pass_q)); // R8
endmodule

// File: rtl/amp_sig_bist.sv
module amp_sig_bist
    import bist_sig_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               start_i,
    input  logic [CNT_W-1:0]   settle_i,
    input  logic [NUM_DET-1:0] det_i,
    output logic               inj_pos_o,
    output logic               inj_neg_o,
    output logic               inj_skew_o,
    output logic               busy_o,
    output logic               done_o,
    output logic               pass_o,
    output logic [SIG_W-1:0]   sig_o,
    output logic [NUM_DET-1:0] mism_o
);
    logic [NUM_DET-1:0] det_s;
    logic               accept;
    logic               sample;
    logic               last;
    logic [STEP_W-1:0]  step;
    inj_t               inj;

    det_sync #(.W(NUM_DET)) u_sync (
        .clk (clk),
        .rst (rst),
        .d_i (det_i),
        .q_o (det_s)
    );

    inj_sequencer #(.CNT_W(CNT_W)) u_seq (
        .clk      (clk),
        .rst      (rst),
        .start_i  (start_i),
        .settle_i (settle_i),
        .busy_o   (busy_o),
        .accept_o (accept),
        .sample_o (sample),
        .last_o   (last),
        .step_o   (step),
        .inj_o    (inj)
    );

    sig_collect u_col (
        .clk      (clk),
        .rst      (rst),
        .clear_i  (accept),
        .sample_i (sample),
        .last_i   (last),
        .step_i   (step),
        .det_i    (det_s),
        .sig_o    (sig_o),
        .mism_o   (mism_o),
        .pass_o   (pass_o),
        .done_o   (done_o)
    );

    assign inj_pos_o  = inj.pos;
    assign inj_neg_o  = inj.neg;
    assign inj_skew_o = inj.skew;

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !busy_o |-> !(inj_pos_o || inj_neg_o || inj_skew_o)); // R1
    AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (rst)
        done_o |-> !busy_o); // R8
    AST_RESET_QUIET: assert property (@(posedge clk)
        rst |=> !busy_o && !done_o && !inj_pos_o && !inj_neg_o && !inj_skew_o); // R10
endmodule

// File: tb/amp_sig_bist_bench.sv
module amp_sig_bist_bench;
    localparam int CNT_W = 8;
    localparam logic [15:0] GOLD = 16'b1111110000111010;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 1'b0;
    logic [CNT_W-1:0] settle = 8'd2;
    logic [3:0] det;
    logic pos, neg, skew, busy, done, pass;
    logic [15:0] sig;
    logic [3:0] mism;

    logic [15:0] flt = '0;
    logic [3:0]  noise = '0;
    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;

    always #2.5 clk = ~clk;

    amp_sig_bist #(.CNT_W(CNT_W)) u_amp_sig_bist (
        .clk(clk), .rst(rst), .start_i(start), .settle_i(settle), .det_i(det),
        .inj_pos_o(pos), .inj_neg_o(neg), .inj_skew_o(skew), .busy_o(busy),
        .done_o(done), .pass_o(pass), .sig_o(sig), .mism_o(mism)
    );

    // Decoded step from the enables, -1 for none, -2 for illegal
    function automatic int dec_step(input logic p, input logic n, input logic k);
        if (!p && !n && !k) return -1;
        if (p && !n) return k ? 2 : 0;
        if (n && !p) return k ? 3 : 1;
        return -2;
    endfunction

    // Detector model: fault-free level per R6 layout, XOR fault word
    always_comb begin
        int s;
        s = dec_step(pos, neg, skew);
        if (s < 0) det = noise;
        else for (int d = 0; d < 4; d++) det[d] = GOLD[4*d+3-s] ^ flt[4*d+3-s];
    end

    function automatic logic [3:0] exp_mask(input logic [15:0] f);
        logic [3:0] m;
        for (int d = 0; d < 4; d++) m[d] = (f[4*d +: 4] != 4'h0);
        return m;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    always @(negedge clk) begin
        cyc++;
        noise <= 4'($urandom);
        if (!rst) begin
            if (pos && neg) begin n_chk++; n_bad++; $display("FAIL R3 actual=11 expected=not both"); end
            if (!busy && (pos || neg || skew)) begin
                n_chk++; n_bad++; $display("FAIL R1 actual=%b%b%b expected=000", pos, neg, skew);
            end
        end
        if (cyc > 150000) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=%0d expected<150000", cyc);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    task automatic run(input int s, input logic [15:0] f, input bit poke);
        int n;
        int order_bad;
        logic [15:0] es;
        flt = f;
        settle = CNT_W'(s);
        es = GOLD ^ f;
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        n = 1;
        order_bad = 0;
        while (!done && n < 200) begin
            if (n <= 4*s+4 && dec_step(pos, neg, skew) != (n-1)/(s+1)) order_bad++;
            if (poke) start = (n == 3);
            @(negedge clk);
            n++;
        end
        start = 1'b0;
        check("R2 step order", 32'(order_bad), 0);
        check(poke ? "R9 latency with extra start" : "R4 latency", 32'(n), 32'(4*s+5));
        check("R8 busy low at done", {31'd0, busy}, 0);
        check("R6 signature", {16'd0, sig}, {16'd0, es});
        check("R7 pass", {31'd0, pass}, {31'd0, (es == GOLD)});
        check("R7 mask", {28'd0, mism}, {28'd0, exp_mask(f)});
        @(negedge clk);
        check("R8 done width", {31'd0, done}, 0);
        repeat (3) @(negedge clk);
        check("R8 result held", {16'd0, sig}, {16'd0, es});
        check("R5 idle noise ignored", {31'd0, pass}, {31'd0, (es == GOLD)});
    endtask

    initial begin
        void'($urandom(32'd20240721));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1 reset enables", {29'd0, pos, neg, skew}, 0);
        check("R10 reset results", {12'd0, sig, mism}, 0);
        check("R1 reset busy", {30'd0, busy, done}, 0);

        run(2, 16'h0000, 0);                  // R5 minimum settle, clean
        for (int d = 0; d < 4; d++)
            for (int s = 0; s < 4; s++)
                run(3, 16'(1) << (4*d + 3 - s), 0);   // R6 single bit
        run(4, 16'h0000, 1);                  // R9
        run(5, 16'hFFFF, 1);                  // R9 all faulty
        for (int i = 0; i < 10; i++)
            run(2 + int'($urandom_range(0, 7)), (i % 3 == 0) ? 16'h0 : 16'($urandom), 0);

        // R10: reset mid-run
        flt = '0;
        settle = 8'd4;
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        repeat (6) @(negedge clk);
        check("R10 busy mid-run", {31'd0, busy}, 1);
        rst = 1'b1;
        @(negedge clk) rst = 1'b0;
        check("R10 enables cleared", {29'd0, pos, neg, skew}, 0);
        check("R10 busy cleared", {31'd0, busy}, 0);
        check("R10 results cleared", {12'd0, sig, mism}, 0);
        begin
            int seen = 0;
            repeat (30) begin
                @(negedge clk);
                if (done) seen++;
            end
            check("R10 no done after reset", 32'(seen), 0);
        end
        run(2, 16'h0000, 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule